// File: doc/BRIEF.md
# CAN Bit Timing and Synchronisation Unit

This unit turns a stream of time-quantum ticks into the internal bit-time structure of a CAN node. Each nominal bit starts with a synchronisation segment one quantum long. A programmable first phase segment follows, and then a programmable second phase segment. When the first phase segment ends, the unit raises a sample strobe and presents the bus level it captured. When the second phase segment ends, it raises a transmit strobe so that the frame logic can drive the next bit.

The unit watches the receive line at each quantum for falling edges, that is recessive-to-dominant transitions. While the surrounding frame logic reports the bus as idle (`hsync_en`), such an edge causes a hard synchronisation. At any other time the edge causes a resynchronisation, and the size of that correction is bounded by a programmable jump width. Dividing the system clock down to the quantum tick is done outside this unit, and so is all frame handling.

Top module: `can_bit_timer`

## Requirements
- R1: With no falling edge on `rx`, two successive transmit strobes are 1 + (`tseg1_cfg`+1) + (`tseg2_cfg`+1) quanta apart. The field encodings are: segment 1 lasts `tseg1_cfg`+1 quanta, segment 2 lasts `tseg2_cfg`+1 quanta, and the jump width is `sjw_cfg`+1 quanta. A legal total lies between 4 and 25 quanta.
- R2: After reset, quantum 0 is the sync segment. `sample_stb` pulses after the quantum numbered `tseg1_cfg`+1 relative to the bit start, and `sample_bit` then holds the `rx` level of that quantum (1 = recessive).
- R3: `tx_stb` pulses after the last quantum of segment 2. It never pulses in the same cycle as `sample_stb`.
- R4: The position within the bit advances only on `tq_tick`. Each strobe is a single-cycle pulse in the clock cycle that follows the tick of its quantum.
- R5: While `hsync_en` is 1, a falling edge makes its own quantum the sync segment of a new bit, and segment 1 restarts at the next quantum. The edge's quantum produces no strobe.
- R6: A falling edge in quantum k of segment 1 (phase error e = k+1) lengthens segment 1 by min(e, jump width).
- R7: A falling edge in segment 2 (phase error e = quanta left to the end of the bit, counting the edge quantum) shortens segment 2 by min(e, jump width). When e is no larger than the jump width, the edge quantum becomes the sync segment of the next bit.
- R8: A rising edge on `rx` has no effect on timing.
- R9: A falling edge inside the sync segment has no effect on timing.
- R10: Only one resynchronisation is applied per bit. A later falling edge in the same bit is ignored, and a hard synchronisation counts as that bit's one correction.
- R11: While reset is asserted, both strobes are 0 and `sample_bit` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tq_tick | input | 1 | One-cycle pulse ending each time quantum |
| rx | input | 1 | Receive line, already synchronous, 1 = recessive |
| hsync_en | input | 1 | Bus idle: a falling edge hard-synchronises |
| tseg1_cfg | input | 4 | Segment 1 length minus one |
| tseg2_cfg | input | 3 | Segment 2 length minus one |
| sjw_cfg | input | 2 | Jump width minus one |
| sample_stb | output | 1 | Sample point pulse |
| sample_bit | output | 1 | Bus level captured at the sample point |
| tx_stb | output | 1 | Transmit point pulse |

## Verification
The assertions assume that the configuration fields are legal and stay constant outside reset. Legal means a bit of 4 to 25 quanta and a jump width no larger than the shorter phase segment. They also assume that `rx` changes level only at quantum boundaries. The bench writes the configuration only while reset is held. It drives `rx` once per quantum from a schedule of low windows, and it spaces the ticks evenly, either every cycle or every third cycle.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef logic [7:0] q_t;

  typedef enum logic [1:0] {
    PH_SYNC = 2'd0,
    PH_SEG1 = 2'd1,
    PH_SEG2 = 2'd2
  } bt_phase_e;

  // Length in quanta of a field coded as "length minus one".
  function automatic q_t seg_quanta(input q_t field);
    return field + 8'd1;
  endfunction

  // Phase correction bounded by the jump width.
  function automatic q_t jump_clip(input q_t err, input q_t width);
    return (err < width) ? err : width;
  endfunction

endpackage

// File: rtl/can_bt_edge.sv
module can_bt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_tick,
  input  logic rx,
  input  logic hsync_en,
  output logic fall_evt,
  output logic hard_evt
);
  logic prev_rx;

  always_ff @(posedge clk) begin
    if (!rst_n)       prev_rx <= 1'b1;
    else if (tq_tick) prev_rx <= rx;
  end

  assign fall_evt = tq_tick & prev_rx & ~rx;
  assign hard_evt = fall_evt & hsync_en;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             fall_evt,
  input  logic             hard_evt,
  input  logic [TS1_W-1:0] tseg1_cfg,
  input  logic [TS2_W-1:0] tseg2_cfg,
  input  logic [SJW_W-1:0] sjw_cfg,
  output logic             sample_evt,
  output logic             tx_evt
);
  localparam int BIT_MAX_Q = 1 + (1 << TS1_W) + (1 << TS2_W);

  bt_phase_e phase_q, phase_n;
  q_t        idx_q, idx_n, ext_q, ext_n, shrink_q, shrink_n;
  logic      done_q, done_n;

  q_t len1, len2, sjw, end1, end2, err1, err2, clip1, clip2;
  logic resync_ok;

  assign len1      = seg_quanta(q_t'(tseg1_cfg));
  assign len2      = seg_quanta(q_t'(tseg2_cfg));
  assign sjw       = seg_quanta(q_t'(sjw_cfg));
  assign end1      = len1 - 8'd1 + ext_q;
  assign end2      = len2 - 8'd1 - shrink_q;
  assign err1      = idx_q + 8'd1;
  assign err2      = len2 - idx_q;
  assign clip1     = jump_clip(err1, sjw);
  assign clip2     = jump_clip(err2, sjw);
  assign resync_ok = fall_evt & ~done_q & ~hard_evt;

  always_comb begin
    phase_n    = phase_q;
    idx_n      = idx_q;
    ext_n      = ext_q;
    shrink_n   = shrink_q;
    done_n     = done_q;
    sample_evt = 1'b0;
    tx_evt     = 1'b0;
    if (tq_tick) begin
      if (hard_evt) begin
        phase_n  = PH_SEG1;
        idx_n    = '0;
        ext_n    = '0;
        shrink_n = '0;
        done_n   = 1'b1;
      end else begin
        unique case (phase_q)
          PH_SYNC: begin
            phase_n  = PH_SEG1;
            idx_n    = '0;
            ext_n    = '0;
            shrink_n = '0;
            done_n   = 1'b0;
          end
          PH_SEG1: begin
            if (resync_ok) begin
              ext_n  = clip1;
              done_n = 1'b1;
              idx_n  = idx_q + 8'd1;
            end else if (idx_q == end1) begin
              sample_evt = 1'b1;
              phase_n    = PH_SEG2;
              idx_n      = '0;
            end else begin
              idx_n = idx_q + 8'd1;
            end
          end
          PH_SEG2: begin
            if (resync_ok && clip2 == err2) begin
              tx_evt   = 1'b1;
              phase_n  = PH_SEG1;
              idx_n    = '0;
              ext_n    = '0;
              shrink_n = '0;
              done_n   = 1'b0;
            end else if (resync_ok && clip2 == err2 - 8'd1) begin
              tx_evt  = 1'b1;
              phase_n = PH_SYNC;
              idx_n   = '0;
            end else if (resync_ok) begin
              shrink_n = clip2;
              done_n   = 1'b1;
              idx_n    = idx_q + 8'd1;
            end else if (idx_q == end2) begin
              tx_evt  = 1'b1;
              phase_n = PH_SYNC;
              idx_n   = '0;
            end else begin
              idx_n = idx_q + 8'd1;
            end
          end
          default: begin
            phase_n = PH_SYNC;
            idx_n   = '0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q  <= PH_SYNC;
      idx_q    <= '0;
      ext_q    <= '0;
      shrink_q <= '0;
      done_q   <= 1'b0;
    end else begin
      phase_q  <= phase_n;
      idx_q    <= idx_n;
      ext_q    <= ext_n;
      shrink_q <= shrink_n;
      done_q   <= done_n;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < q_t'(BIT_MAX_Q)); // R1
  AST_SEG1_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_SEG1 |-> idx_q <= end1); // R1
  AST_SEG2_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == PH_SEG2 |-> idx_q <= end2); // R3
  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tq_tick |=> $stable(idx_q) && $stable(phase_q)); // R4
  AST_HARD_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hard_evt |=> phase_q == PH_SEG1 && idx_q == 8'd0); // R5
  AST_EXT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ext_q <= sjw); // R6
  AST_SHRINK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    shrink_q <= sjw); // R7
  AST_SYNC_NO_CORR: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && phase_q == PH_SYNC) |=> ext_q == 8'd0 && shrink_q == 8'd0); // R9
  AST_ONE_RESYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick && done_q && phase_q == PH_SEG1 && !hard_evt) |=> ext_q == $past(ext_q)); // R10
endmodule

// File: rtl/can_bt_out.sv
module can_bt_out (
  input  logic clk,
  input  logic rst_n,
  input  logic tq_tick,
  input  logic rx,
  input  logic sample_evt,
  input  logic tx_evt,
  output logic sample_stb,
  output logic sample_bit,
  output logic tx_stb
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
      sample_bit <= 1'b1;
    end else begin
      sample_stb <= sample_evt;
      tx_stb     <= tx_evt;
      if (sample_evt) sample_bit <= rx;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && tx_stb)); // R3
  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb || tx_stb) |-> $past(tq_tick)); // R4
  AST_SAMPLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> sample_bit == $past(rx)); // R2
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tq_tick,
  input  logic             rx,
  input  logic             hsync_en,
  input  logic [TS1_W-1:0] tseg1_cfg,
  input  logic [TS2_W-1:0] tseg2_cfg,
  input  logic [SJW_W-1:0] sjw_cfg,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             tx_stb
);
  logic fall_evt, hard_evt, sample_evt, tx_evt;

  can_bt_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .tq_tick  (tq_tick),
    .rx       (rx),
    .hsync_en (hsync_en),
    .fall_evt (fall_evt),
    .hard_evt (hard_evt)
  );

  can_bt_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_tick    (tq_tick),
    .fall_evt   (fall_evt),
    .hard_evt   (hard_evt),
    .tseg1_cfg  (tseg1_cfg),
    .tseg2_cfg  (tseg2_cfg),
    .sjw_cfg    (sjw_cfg),
    .sample_evt (sample_evt),
    .tx_evt     (tx_evt)
  );

  can_bt_out u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .tq_tick    (tq_tick),
    .rx         (rx),
    .sample_evt (sample_evt),
    .tx_evt     (tx_evt),
    .sample_stb (sample_stb),
    .sample_bit (sample_bit),
    .tx_stb     (tx_stb)
  );
endmodule

// File: tb/can_bit_timer_bench.sv
module can_bit_timer_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, tq_tick, rx, hsync_en;
  logic [3:0] t1;
  logic [2:0] t2;
  logic [1:0] sj;
  wire        sample_stb, sample_bit, tx_stb;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx(rx), .hsync_en(hsync_en),
    .tseg1_cfg(t1), .tseg2_cfg(t2), .sjw_cfg(sj),
    .sample_stb(sample_stb), .sample_bit(sample_bit), .tx_stb(tx_stb)
  );

  int checks = 0, fails = 0;
  int samp_q[16];
  int samp_b[16];
  int tx_q[16];
  int ns, nt, stray;
  int lo0s, lo0e, lo1s, lo1e;

  // {tseg1_cfg, tseg2_cfg, first sample quantum, first tx quantum}
  localparam logic [16:0] VEC [4] = '{
    {4'd1,  3'd0, 5'd2,  5'd3},
    {4'd15, 3'd7, 5'd16, 5'd24},
    {4'd5,  3'd3, 5'd6,  5'd10},
    {4'd3,  3'd6, 5'd4,  5'd11}
  };

  function automatic logic rx_at(input int q);
    return !((q >= lo0s && q < lo0e) || (q >= lo1s && q < lo1e));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic setup(input logic [3:0] a, input logic [2:0] b, input logic [1:0] c,
                       input logic hs);
    @(negedge clk);
    rst_n = 1'b0; tq_tick = 1'b0; rx = 1'b1;
    t1 = a; t2 = b; sj = c; hsync_en = hs;
    lo0s = -1; lo0e = -1; lo1s = -1; lo1e = -1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic observe(input logic ptick, input int pq);
    if (sample_stb) begin
      if (!ptick) stray++;
      else if (ns < 16) begin samp_q[ns] = pq; samp_b[ns] = int'(sample_bit); ns++; end
    end
    if (tx_stb) begin
      if (!ptick) stray++;
      else if (nt < 16) begin tx_q[nt] = pq; nt++; end
    end
  endtask

  task automatic run(input int n, input int gap);
    logic ptick;
    int   pq;
    ptick = 1'b0; pq = 0; ns = 0; nt = 0; stray = 0;
    for (int i = 0; i < 16; i++) begin samp_q[i] = -1; samp_b[i] = -1; tx_q[i] = -1; end
    for (int q = 0; q < n; q++) begin
      for (int c = 0; c < gap; c++) begin
        @(negedge clk);
        observe(ptick, pq);
        rx = rx_at(q);
        tq_tick = (c == gap - 1);
        ptick = tq_tick; pq = q;
      end
    end
    @(negedge clk);
    observe(ptick, pq);
    tq_tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R11 reset state
    setup(4'd3, 3'd2, 2'd0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 sample_stb", int'(sample_stb), 0);
    check("R11 tx_stb", int'(tx_stb), 0);
    check("R11 sample_bit", int'(sample_bit), 1);

    // Table: free-running bits, no edges
    for (int v = 0; v < 4; v++) begin
      int n;
      setup(VEC[v][16:13], VEC[v][12:10], 2'd0, 1'b0);
      n = int'(VEC[v][4:0]) + 1;
      run(2 * n, 1);
      check("R2 first sample", samp_q[0], int'(VEC[v][9:5]));
      check("R2 sample_bit", samp_b[0], 1);
      check("R3 first tx", tx_q[0], int'(VEC[v][4:0]));
      check("R1 bit period", tx_q[1] - tx_q[0], n);
      check("R4 stray strobes", stray, 0);
    end

    // R4 ticks every third cycle, L1=4 L2=3
    setup(4'd3, 3'd2, 2'd0, 1'b0);
    run(13, 3);
    check("R4 gapped sample", samp_q[0], 4);
    check("R4 gapped tx", tx_q[0], 7);
    check("R4 gapped second sample", samp_q[1], 12);
    check("R4 stray strobes", stray, 0);

    // R9 fall in sync of bit 1, R8 rise in its segment 1
    setup(4'd3, 3'd2, 2'd3, 1'b0);
    lo0s = 8; lo0e = 11;
    run(24, 1);
    check("R9 sample after sync edge", samp_q[1], 12);
    check("R8 sample after rise", samp_q[2], 20);
    check("R9 tx", tx_q[1], 15);
    check("R8 sample_bit", samp_b[1], 1);

    // R5 hard sync inside segment 2
    setup(4'd3, 3'd2, 2'd0, 1'b1);
    lo0s = 6; lo0e = 20;
    run(16, 1);
    check("R5 sample before", samp_q[0], 4);
    check("R5 sample after hard sync", samp_q[1], 10);
    check("R5 sample_bit", samp_b[1], 0);
    check("R5 tx", tx_q[0], 13);

    // R6 lengthening, L1=8 L2=4 jump 2
    setup(4'd7, 3'd3, 2'd1, 1'b0);
    lo0s = 1; lo0e = 3;
    run(24, 1);
    check("R6 e=1 sample", samp_q[0], 9);
    check("R6 e=1 tx", tx_q[0], 13);
    check("R6 e=1 next sample", samp_q[1], 22);

    setup(4'd7, 3'd3, 2'd1, 1'b0);
    lo0s = 5; lo0e = 12;
    run(20, 1);
    check("R6 clipped sample", samp_q[0], 10);
    check("R6 sample_bit", samp_b[0], 0);
    check("R6 clipped tx", tx_q[0], 14);

    // R7 shortening
    setup(4'd7, 3'd3, 2'd1, 1'b0);
    lo0s = 12; lo0e = 14;
    run(22, 1);
    check("R7 e=1 tx", tx_q[0], 12);
    check("R7 e=1 next sample", samp_q[1], 20);

    setup(4'd7, 3'd3, 2'd1, 1'b0);
    lo0s = 10; lo0e = 14;
    run(22, 1);
    check("R7 e=3 tx", tx_q[0], 10);
    check("R7 e=3 next sample", samp_q[1], 19);

    setup(4'd7, 3'd3, 2'd0, 1'b0);
    lo0s = 9; lo0e = 14;
    run(22, 1);
    check("R7 clipped tx", tx_q[0], 11);
    check("R7 clipped next sample", samp_q[1], 20);

    // R10 second fall in the same bit
    setup(4'd7, 3'd3, 2'd1, 1'b0);
    lo0s = 2; lo0e = 5; lo1s = 12; lo1e = 13;
    run(26, 1);
    check("R10 sample", samp_q[0], 10);
    check("R10 tx", tx_q[0], 14);
    check("R10 next sample", samp_q[1], 23);

    // R11 reset while running
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 sample_bit after reset", int'(sample_bit), 1);
    check("R11 tx_stb after reset", int'(tx_stb), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule